// File: doc/BRIEF.md
# Dual-Mode Heartbeat Watchdog Supervisor

This block watches a processor heartbeat and raises an active-low watchdog flag when the heartbeat stops toggling for too long. A heartbeat edge in either direction counts as a valid service. After every reset event the watchdog first uses a long initial window, so that a slow boot can complete. It then switches to a short normal window. The switch happens on the first heartbeat edge or when the long window runs out, whichever comes first. All periods are parameters counted in clock cycles.

The block also makes the system reset. `por_n` carries the power-on and brownout request and is asynchronous. `mr_n` is a synchronized manual reset request. The reset output stays low for a fixed number of cycles after the last source is released. With the loop-back parameter set, a watchdog timeout feeds the reset generator, which produces a fixed-length reset pulse. The watchdog is then re-armed in long mode. With loop-back cleared, the watchdog flag stays low until the next heartbeat edge.

The controller is a state machine with five states:
- `WD_HOLD`: reset is active and the counter is held at zero.
- `WD_LONG`: the initial window is running.
- `WD_SHORT`: the normal window is running.
- `WD_EXPIRED`: a timeout has occurred with loop-back off, so the flag is latched low.
- `WD_TRIP`: a timeout has occurred with loop-back on. This state lasts one cycle and requests a reset.

Its transitions are:
- reset-enter: any state goes to `WD_HOLD` whenever a reset source is active or the reset output is low.
- release: `WD_HOLD` goes to `WD_LONG`.
- first-service: `WD_LONG` goes to `WD_SHORT` on a heartbeat edge.
- long-expiry: `WD_LONG` goes to `WD_SHORT` when the window ends.
- service: `WD_SHORT` stays in `WD_SHORT` on a heartbeat edge and clears the counter.
- timeout: `WD_SHORT` goes to `WD_EXPIRED`, or to `WD_TRIP` when loop-back is on.
- recover: `WD_EXPIRED` goes to `WD_SHORT` on a heartbeat edge.
- trip-reset: `WD_TRIP` goes to `WD_HOLD`.

Top module: `wdog_supervisor`

## Requirements
- R1: While `por_n` is low, `rst_out_n` is low and `wdo_n` is high. `wdo_n` is high in every cycle in which `rst_out_n` is low.
- R2: `rst_out_n` rises exactly RST_CYC clock edges after the last edge at which a reset source was sampled active. It stays low while any source is active.
- R3: `mr_n` passes through a two-flop synchronizer. Holding it low pulls `rst_out_n` low after the third rising clock edge.
- R4: A rising edge and a falling edge of `hb` both count as a service. The service is seen at the third rising clock edge after `hb` changes, and it restarts the count in short mode.
- R5: When reset ends, the watchdog enters long mode with a cleared counter. No timeout occurs there within LONG_CYC cycles.
- R6: Long mode changes to short mode on the first service, or after LONG_CYC cycles without one. Neither change lowers `wdo_n`.
- R7: In short mode, `wdo_n` goes low SHORT_CYC cycles after the last service if no further service arrives.
- R8: With LOOPBACK = 0, `wdo_n` stays low after a timeout until the next heartbeat edge. That edge raises it and starts a new short window.
- R9: With LOOPBACK = 1, a timeout lowers `wdo_n` for one cycle. It then drives `rst_out_n` low for exactly RST_CYC cycles, with `wdo_n` high again and the counter cleared.
- R10: After a loop-back reset ends, the watchdog restarts in long mode.
- R11: The timeout counter saturates at the larger period and never wraps.
- R12: While `rst_out_n` is low, the counter stays at zero and heartbeat edges have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on/brownout reset request |
| mr_n | input | 1 | Active-low manual reset request, asynchronous to `clk` |
| hb | input | 1 | Processor heartbeat, asynchronous to `clk` |
| wdo_n | output | 1 | Active-low watchdog timeout flag |
| rst_out_n | output | 1 | Active-low system reset output |

## Verification
The bench builds two copies of the block with LONG_CYC = 40, SHORT_CYC = 10 and RST_CYC = 6. The copies differ only in the loop-back parameter. These short periods put a full long window, a short expiry, a loop-back reset pulse and the second long window of the re-armed watchdog inside a few hundred cycles, so each of them can be checked at its exact edge. The ratio of long to short is kept at four, so a check taken a few cycles past the short period separates the two modes clearly.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [2:0] {
        WD_HOLD    = 3'd0,
        WD_LONG    = 3'd1,
        WD_SHORT   = 3'd2,
        WD_EXPIRED = 3'd3,
        WD_TRIP    = 3'd4
    } wd_state_e;

    function automatic int wd_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) stg[i] <= RST_VAL;
                    else        stg[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) stg[i] <= RST_VAL;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/wdog_rst_stretch.sv
module wdog_rst_stretch #(
    parameter int RST_CYC = 6
) (
    input  logic clk,
    input  logic por_n,
    input  logic src,
    output logic rst_n_q
);

    localparam int             RW   = (RST_CYC < 2) ? 1 : $clog2(RST_CYC + 1);
    localparam logic [RW-1:0]  LAST = RW'(RST_CYC - 1);

    logic [RW-1:0] cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt     <= '0;
            rst_n_q <= 1'b0;
        end else if (src) begin
            cnt     <= '0;
            rst_n_q <= 1'b0;
        end else if (!rst_n_q) begin
            if (cnt == LAST) rst_n_q <= 1'b1;
            else             cnt     <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int MAXP = 40,
    parameter int CW   = 6
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] TOP = CW'(MAXP);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt != TOP) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/wdog_mode_fsm.sv
module wdog_mode_fsm
    import wdog_pkg::*;
#(
    parameter int LONG_CYC  = 40,
    parameter int SHORT_CYC = 10,
    parameter bit LOOPBACK  = 1'b0,
    parameter int CW        = 6
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          hold,
    input  logic          hb_edge,
    input  logic [CW-1:0] cnt,
    output wd_state_e     state,
    output logic          cnt_clr,
    output logic          wdo_n
);

    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);

    wd_state_e nxt;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= WD_HOLD;
        else        state <= nxt;
    end

    // next state and counter clear
    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        if (hold) begin
            nxt     = WD_HOLD;
            cnt_clr = 1'b1;
        end else begin
            unique case (state)
                WD_HOLD: begin
                    nxt     = WD_LONG;
                    cnt_clr = 1'b1;
                end
                WD_LONG: begin
                    if (hb_edge || cnt == LONG_LAST) begin
                        nxt     = WD_SHORT;
                        cnt_clr = 1'b1;
                    end
                end
                WD_SHORT: begin
                    if (hb_edge) begin
                        cnt_clr = 1'b1;
                    end else if (cnt == SHORT_LAST) begin
                        nxt     = LOOPBACK ? WD_TRIP : WD_EXPIRED;
                        cnt_clr = 1'b1;
                    end
                end
                WD_EXPIRED: begin
                    if (hb_edge) begin
                        nxt     = WD_SHORT;
                        cnt_clr = 1'b1;
                    end
                end
                WD_TRIP: begin
                    nxt     = WD_HOLD;
                    cnt_clr = 1'b1;
                end
                default: begin
                    nxt     = WD_HOLD;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            WD_EXPIRED, WD_TRIP: wdo_n = 1'b0;
            default:             wdo_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int LONG_CYC  = 35_000_000,
    parameter int SHORT_CYC = 1_120_000,
    parameter int RST_CYC   = 200_000,
    parameter bit LOOPBACK  = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic mr_n,
    input  logic hb,
    output logic wdo_n,
    output logic rst_out_n
);

    localparam int MAXP = wd_max(LONG_CYC, SHORT_CYC);
    localparam int CW   = $clog2(MAXP + 1);

    logic [1:0]    sync_q;
    logic          mr_s;
    logic          hb_s;
    logic          hb_q;
    logic          hb_edge;
    logic          rst_src;
    logic          trip_req;
    logic          hold;
    logic          tmr_clr;
    logic [CW-1:0] tmr_cnt;
    wd_state_e     fsm_state;

    wdog_sync #(
        .WIDTH   (2),
        .STAGES  (2),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d     ({hb, mr_n}),
        .q     (sync_q)
    );

    assign mr_s = sync_q[0];
    assign hb_s = sync_q[1];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) hb_q <= 1'b0;
        else        hb_q <= hb_s;
    end

    assign hb_edge  = hb_s ^ hb_q;
    assign trip_req = (fsm_state == WD_TRIP);
    assign rst_src  = !mr_s || trip_req;
    assign hold     = rst_src || !rst_out_n;

    wdog_rst_stretch #(
        .RST_CYC (RST_CYC)
    ) u_rst (
        .clk     (clk),
        .por_n   (por_n),
        .src     (rst_src),
        .rst_n_q (rst_out_n)
    );

    wdog_timer #(
        .MAXP (MAXP),
        .CW   (CW)
    ) u_tmr (
        .clk   (clk),
        .por_n (por_n),
        .clr   (tmr_clr),
        .cnt   (tmr_cnt)
    );

    wdog_mode_fsm #(
        .LONG_CYC  (LONG_CYC),
        .SHORT_CYC (SHORT_CYC),
        .LOOPBACK  (LOOPBACK),
        .CW        (CW)
    ) u_fsm (
        .clk     (clk),
        .por_n   (por_n),
        .hold    (hold),
        .hb_edge (hb_edge),
        .cnt     (tmr_cnt),
        .state   (fsm_state),
        .cnt_clr (tmr_clr),
        .wdo_n   (wdo_n)
    );

endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk
    import wdog_pkg::*;
#(
    parameter int LONG_CYC  = 40,
    parameter int SHORT_CYC = 10,
    parameter int RST_CYC   = 6,
    parameter bit LOOPBACK  = 1'b0,
    parameter int CW        = 6
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          hb_edge,
    input  logic          rst_src,
    input  wd_state_e     state,
    input  logic [CW-1:0] cnt,
    input  logic          wdo_n,
    input  logic          rst_out_n
);

    localparam int            MAXP       = wd_max(LONG_CYC, SHORT_CYC);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);
    localparam logic [CW-1:0] CNT_TOP    = CW'(MAXP);
    localparam int            KW         = $clog2(RST_CYC + 2);
    localparam logic [KW-1:0] K_TOP      = KW'(RST_CYC + 1);

    // cycles since a reset source was last sampled active
    logic [KW-1:0] since_src;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)               since_src <= '0;
        else if (rst_src)         since_src <= '0;
        else if (since_src != K_TOP) since_src <= since_src + 1'b1;
    end

    a_r1_wdo_high_in_reset: assert property (@(posedge clk) disable iff (!por_n)
        !rst_out_n |-> wdo_n);

    a_r12_held_clear: assert property (@(posedge clk) disable iff (!por_n)
        !rst_out_n |-> (state == WD_HOLD && cnt == '0));

    a_r2_stretch_len: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_out_n) |-> since_src == KW'(RST_CYC));

    a_r2_src_low: assert property (@(posedge clk) disable iff (!por_n)
        rst_src |=> !rst_out_n);

    a_r4_edge_restart: assert property (@(posedge clk) disable iff (!por_n)
        (rst_out_n && !rst_src && hb_edge && state != WD_HOLD && state != WD_TRIP)
        |=> (state == WD_SHORT && cnt == '0));

    a_r5_enter_long: assert property (@(posedge clk) disable iff (!por_n)
        (state != WD_HOLD && $past(state) == WD_HOLD) |-> (state == WD_LONG && cnt == '0));

    a_r6_long_expiry: assert property (@(posedge clk) disable iff (!por_n)
        (state == WD_LONG && cnt == LONG_LAST && !hb_edge && !rst_src)
        |=> (state == WD_SHORT && cnt == '0 && wdo_n));

    a_r7_short_expiry: assert property (@(posedge clk) disable iff (!por_n)
        (state == WD_SHORT && cnt == SHORT_LAST && !hb_edge && !rst_src) |=> !wdo_n);

    a_r8_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (!LOOPBACK && !wdo_n && !hb_edge && !rst_src) |=> !wdo_n);

    a_r9_trip_reset: assert property (@(posedge clk) disable iff (!por_n)
        (LOOPBACK && !wdo_n) |=> (!rst_out_n && wdo_n));

    a_r11_bound: assert property (@(posedge clk) disable iff (!por_n)
        cnt <= CNT_TOP);

    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!por_n)
        cnt == CNT_TOP |=> (cnt == CNT_TOP || cnt == '0));

endmodule

bind wdog_supervisor wdog_supervisor_chk #(
    .LONG_CYC  (LONG_CYC),
    .SHORT_CYC (SHORT_CYC),
    .RST_CYC   (RST_CYC),
    .LOOPBACK  (LOOPBACK),
    .CW        (CW)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .hb_edge   (hb_edge),
    .rst_src   (rst_src),
    .state     (fsm_state),
    .cnt       (tmr_cnt),
    .wdo_n     (wdo_n),
    .rst_out_n (rst_out_n)
);

// File: tb/sim_wdog_supervisor.sv
module sim_wdog_supervisor;

    localparam int LONG  = 40;
    localparam int SHORT = 10;
    localparam int RST   = 6;
    localparam int T     = RST + 1 + LONG + SHORT;    // edge at which the first timeout lands
    localparam int NV    = 14;
    // heartbeat toggle, then wait GAP edges, then expect wdo_n == EXPV
    localparam int GAP  [NV] = '{5, 12, 13, 20, 3, 8, 12, 14, 30, 4, 80, 6, 15, 9};
    localparam bit EXPV [NV] = '{1,  1,  0,  0, 1, 1,  1,  0,  0, 1,  0, 1,  0, 1};

    logic clk = 1'b0;
    logic por_n, mr_n, hb0, hb1;
    logic wdo0, rst0, wdo1, rst1;
    int   n_chk  = 0;
    int   n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    wdog_supervisor #(.LONG_CYC(LONG), .SHORT_CYC(SHORT), .RST_CYC(RST), .LOOPBACK(1'b0)) u0 (
        .clk(clk), .por_n(por_n), .mr_n(mr_n), .hb(hb0), .wdo_n(wdo0), .rst_out_n(rst0));

    wdog_supervisor #(.LONG_CYC(LONG), .SHORT_CYC(SHORT), .RST_CYC(RST), .LOOPBACK(1'b1)) u1 (
        .clk(clk), .por_n(por_n), .mr_n(mr_n), .hb(hb1), .wdo_n(wdo1), .rst_out_n(rst1));

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        por_n = 1'b0; mr_n = 1'b1; hb0 = 1'b0; hb1 = 1'b0;
        step(3);
        chk("R1 rst0 during por", rst0, 1'b0);
        chk("R1 wdo0 during por", wdo0, 1'b1);
        chk("R1 rst1 during por", rst1, 1'b0);
        chk("R1 wdo1 during por", wdo1, 1'b1);

        por_n = 1'b1;
        step(RST - 1);
        chk("R2 rst0 still low", rst0, 1'b0);
        chk("R2 rst1 still low", rst1, 1'b0);
        step(1);
        chk("R2 rst0 released", rst0, 1'b1);
        chk("R2 rst1 released", rst1, 1'b1);

        step(SHORT + 5);                       // k = RST+SHORT+5, beyond a short window
        chk("R5 wdo0 long mode", wdo0, 1'b1);
        chk("R5 wdo1 long mode", wdo1, 1'b1);

        step(LONG - 5);                        // k = T-1
        chk("R6 wdo0 long then short", wdo0, 1'b1);
        chk("R9 wdo1 before trip", wdo1, 1'b1);
        step(1);                               // k = T
        chk("R7 wdo0 short expiry", wdo0, 1'b0);
        chk("R9 wdo1 trip pulse", wdo1, 1'b0);
        chk("R9 rst1 before pulse", rst1, 1'b1);
        step(1);                               // k = T+1
        chk("R9 rst1 pulse start", rst1, 1'b0);
        chk("R9 wdo1 back high", wdo1, 1'b1);
        step(RST - 1);
        chk("R9 rst1 pulse held", rst1, 1'b0);
        step(1);                               // k = T+1+RST
        chk("R9 rst1 pulse end", rst1, 1'b1);
        step(SHORT + 5);
        chk("R10 wdo1 long re-armed", wdo1, 1'b1);
        step(LONG - 5);                        // one edge before second trip
        chk("R10 wdo1 before second trip", wdo1, 1'b1);
        step(1);
        chk("R10 wdo1 second trip", wdo1, 1'b0);
        chk("R8 wdo0 stays low", wdo0, 1'b0);

        // vector walk on u0: alternating rising/falling heartbeat edges (R4),
        // expiries (R7), latched flag and release (R8), long saturation (R11)
        for (int i = 0; i < NV; i++) begin
            hb0 = ~hb0;
            step(GAP[i]);
            chk($sformatf("R4 R7 R8 R11 vector %0d", i), wdo0, EXPV[i]);
        end

        // manual reset: R3 latency, R12 edges ignored while held
        mr_n = 1'b0;
        step(2);
        chk("R3 rst0 sync delay", rst0, 1'b1);
        step(1);
        chk("R3 rst0 asserted", rst0, 1'b0);
        chk("R3 rst1 asserted", rst1, 1'b0);
        chk("R1 wdo0 high in reset", wdo0, 1'b1);
        for (int j = 0; j < 6; j++) begin
            hb0 = ~hb0;
            step(3);
        end
        step(LONG + SHORT + 10);
        chk("R12 wdo0 held", wdo0, 1'b1);
        chk("R12 rst0 held", rst0, 1'b0);
        mr_n = 1'b1;
        step(RST + 1);
        chk("R3 rst0 stretch", rst0, 1'b0);
        step(1);                               // k = RST+2
        chk("R3 rst0 released", rst0, 1'b1);
        step(SHORT + 5);
        chk("R5 wdo0 long after manual reset", wdo0, 1'b1);
        step(LONG - 5);                        // k = RST+2+LONG+SHORT
        chk("R6 wdo0 before expiry", wdo0, 1'b1);
        step(2);
        chk("R7 wdo0 expiry after manual reset", wdo0, 1'b0);

        report();
    end

endmodule